// File: doc/BRIEF.md
# Parallel Host Access Port for a Time-Slot Switch

This block is the host side of a time-slot switch. An 8-bit parallel bus with separate address and data lines reaches it. That bus has an active-low chip select, an active-high data strobe, a read/write line and an active-low acknowledge. The address field is only six bits wide. Its top bit chooses between the control register and the channel space, and the low five bits name one of 32 channels. A control register fills in the rest of a memory address: a stream number and a memory-select field.

A host memory access does not reach the memories directly. The port raises a request toward the switching core's time-division schedule. It holds the request until the scheduler grants it a free slot, then acknowledges the host. So the acknowledge latency depends on how busy the schedule is. The control register also carries a processor-enable flag, which is exported to the switching core. It carries a split flag as well, which sends host reads to the data memory and host writes to connection memory low.

Inputs are taken to be synchronous to `clk` already. The data bus is split into separate in and out halves with an output-enable, so the pad ring can build the shared bus.

Top module: `host_access_port`

## Requirements
- R1: After reset, `hp_ack_n` is 1, `mem_req` is 0, `proc_en` is 0, and the control register reads back 0.
- R2: The control register is addressed when address bit 5 is 0 and bits 1:0 are 00. Bits 4:2 are don't-care. Such an access is acknowledged one cycle after the strobe is sampled, with no memory request. Reserved bits 5 and 2 read back as 0.
- R3: No access starts unless `hp_cs_n` is 0 and `hp_ds` is 1 together. Otherwise there is no acknowledge, no request and no register change.
- R4: `proc_en` follows control register bit 6.
- R5: With address bit 5 set, a request is raised with `mem_addr` = {control bits 1:0 (stream), address bits 4:0 (channel)}. The target `mem_sel` comes from control bits 4:3: 01 selects connection memory low, 10 selects connection memory high, 11 selects the data memory.
- R6: `mem_req` and its fields stay stable until a cycle with `mem_gnt` high. In the cycle after that one, `mem_req` is 0 and `hp_ack_n` is 0.
- R7: On a read, `hp_rdata` carries `mem_rdata` as sampled in the grant cycle, with `hp_rdata_oe` high, for as long as the acknowledge is low.
- R8: `hp_ack_n` stays low while the strobe and chip select are both active. It returns to 1 one cycle after either goes inactive.
- R9: With control bit 7 (split) set, reads target the data memory (11) and writes target connection memory low (01), whatever bits 4:3 hold.
- R10: A write aimed at the data memory, any access with memory-select 00, and any address with bit 5 at 0 and bits 1:0 nonzero are acknowledged after one cycle. They raise no request, change nothing, and read as 0.
- R11: During a request, `mem_we` is the inverse of `hp_rw` (1 means read), and `mem_wdata` is the host write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hp_cs_n | input | 1 | Chip select, active low |
| hp_ds | input | 1 | Data strobe, active high |
| hp_rw | input | 1 | 1 = read, 0 = write |
| hp_addr | input | CH_W+1 | Top bit: channel space; low bits: channel or register |
| hp_wdata | input | 8 | Host write data |
| hp_rdata | output | 8 | Host read data, 0 when not driven |
| hp_rdata_oe | output | 1 | Drive enable for the read data |
| hp_ack_n | output | 1 | Transfer acknowledge, active low |
| proc_en | output | 1 | Processor-enable flag for the switching core |
| mem_req | output | 1 | Memory access request to the scheduler |
| mem_we | output | 1 | Request is a write |
| mem_sel | output | 2 | Target: 01 CM low, 10 CM high, 11 data memory |
| mem_addr | output | STREAM_W+CH_W | {stream, channel} |
| mem_wdata | output | 8 | Write data for the memory |
| mem_gnt | input | 1 | Scheduler grants the pending request this cycle |
| mem_rdata | input | 8 | Read data, valid in the grant cycle |

## Verification
A control-register access or an ignored access shows its acknowledge one cycle after the strobe is sampled. A memory access shows its request one cycle after the strobe is sampled and its acknowledge one cycle after the grant cycle. The acknowledge is therefore due grant-delay plus two cycles after the strobe. The acknowledge is released one cycle after the strobe drops. The bench drives every input on a falling edge and reads the outputs on later falling edges. It counts the exact number of cycles until the acknowledge and compares that count, the captured request fields and the returned data against values it works out from the requirements.

// File: rtl/hp_port_pkg.sv
// Shared constants and types for the host access port.
// Assumes an 8-bit host data bus. The control-field bit positions are fixed
// because host software relies on them.
package hp_port_pkg;
    localparam int HP_DATA_W     = 8;
    localparam int CTL_SPLIT_BIT = 7;
    localparam int CTL_PE_BIT    = 6;
    localparam int CTL_MSEL_LO   = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_CML  = 2'b01,
        SEL_CMH  = 2'b10,
        SEL_DM   = 2'b11
    } hp_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_ACK  = 2'b10
    } hp_state_e;
endpackage

// File: rtl/hp_ctl_reg.sv
// Control register of the host port. It holds the split flag, the processor-
// enable flag, memory select and stream number. Reserved bits are not stored.
// Assumes STREAM_W <= 3 so that the stream field stays below the select field.
module hp_ctl_reg
    import hp_port_pkg::*;
#(
    parameter int STREAM_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [HP_DATA_W-1:0] wr_data,
    output logic [HP_DATA_W-1:0] rd_data,
    output logic                 split,
    output logic                 proc_en,
    output hp_sel_e              msel,
    output logic [STREAM_W-1:0]  stream
);
    // Mask of the implemented bits, derived from the field layout.
    function automatic logic [HP_DATA_W-1:0] impl_mask();
        logic [HP_DATA_W-1:0] m;
        m = '0;
        m[CTL_SPLIT_BIT] = 1'b1;
        m[CTL_PE_BIT] = 1'b1;
        m[CTL_MSEL_LO] = 1'b1;
        m[CTL_MSEL_LO+1] = 1'b1;
        for (int i = 0; i < STREAM_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [HP_DATA_W-1:0] MASK = impl_mask();

    logic [HP_DATA_W-1:0] ctl_q;

    // Register update: cleared on reset, loaded on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data & MASK;
    end

    // Field extraction for the decoder and the switching core.
    always_comb begin
        rd_data = ctl_q;
        split   = ctl_q[CTL_SPLIT_BIT];
        proc_en = ctl_q[CTL_PE_BIT];
        msel    = hp_sel_e'(ctl_q[CTL_MSEL_LO+1:CTL_MSEL_LO]);
        stream  = ctl_q[STREAM_W-1:0];
    end

    // R2: only implemented bits ever become set after a write.
    a_r2_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data & ~MASK) == '0));
endmodule

// File: rtl/hp_decode.sv
// Address decoder for the host port. It classifies an access as a control-
// register hit, a memory hit (with its target) or a null access.
// Purely combinational; the address is assumed to be stable during the strobe.
module hp_decode
    import hp_port_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic      [CH_W:0] addr,
    input  logic               rw,
    input  logic               split,
    input  hp_sel_e            msel,
    output logic               hit_ctl,
    output logic               hit_mem,
    output hp_sel_e            tgt
);
    logic    in_chan_space;
    hp_sel_e eff_sel;

    // Classify the access and choose the target memory.
    always_comb begin
        in_chan_space = addr[CH_W];
        hit_ctl = !in_chan_space && (addr[1:0] == 2'b00);
        if (split) eff_sel = rw ? SEL_DM : SEL_CML;
        else       eff_sel = msel;
        tgt = eff_sel;
        hit_mem = in_chan_space && (eff_sel != SEL_NONE)
                  && !(eff_sel == SEL_DM && !rw);
    end
endmodule

// File: rtl/hp_access_fsm.sv
// Handshake engine for the host port. It starts an access when chip select
// and the strobe are both active, and latches the memory command. It holds
// the request until the scheduler grants it, then acknowledges until the host
// releases the strobe. Assumes host inputs are synchronous to clk.
module hp_access_fsm
    import hp_port_pkg::*;
#(
    parameter int CH_W     = 5,
    parameter int STREAM_W = 2,
    localparam int MA_W    = STREAM_W + CH_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ds,
    input  logic                 rw,
    input  logic [CH_W-1:0]      chan,
    input  logic [STREAM_W-1:0]  stream,
    input  logic [HP_DATA_W-1:0] wdata,
    input  logic                 hit_ctl,
    input  logic                 hit_mem,
    input  hp_sel_e              tgt,
    input  logic [HP_DATA_W-1:0] ctl_rd,
    input  logic                 mem_gnt,
    input  logic [HP_DATA_W-1:0] mem_rdata,
    output logic                 ctl_wr_en,
    output logic                 ack_n,
    output logic [HP_DATA_W-1:0] rdata,
    output logic                 rdata_oe,
    output logic                 mem_req,
    output logic                 mem_we,
    output hp_sel_e              mem_sel,
    output logic [MA_W-1:0]      mem_addr,
    output logic [HP_DATA_W-1:0] mem_wdata
);
    hp_state_e            state_q;
    logic                 rw_q;
    logic [HP_DATA_W-1:0] rd_q;
    logic                 active;

    // Strobe qualification and control-register write pulse.
    always_comb begin
        active    = !cs_n && ds;
        ctl_wr_en = (state_q == ST_IDLE) && active && hit_ctl && !rw;
    end

    // Access sequencing: idle, waiting for grant, acknowledging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rw_q      <= 1'b0;
            rd_q      <= '0;
            mem_we    <= 1'b0;
            mem_sel   <= SEL_NONE;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (active) begin
                    rw_q <= rw;
                    if (hit_mem) begin
                        state_q   <= ST_REQ;
                        mem_we    <= !rw;
                        mem_sel   <= tgt;
                        mem_addr  <= {stream, chan};
                        mem_wdata <= wdata;
                    end else begin
                        state_q <= ST_ACK;
                        rd_q    <= hit_ctl ? ctl_rd : '0;
                    end
                end
                ST_REQ: if (mem_gnt) begin
                    state_q <= ST_ACK;
                    rd_q    <= rw_q ? mem_rdata : '0;
                end
                ST_ACK: if (!active) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Host-facing and scheduler-facing outputs from the state.
    always_comb begin
        mem_req  = (state_q == ST_REQ);
        ack_n    = (state_q != ST_ACK);
        rdata_oe = (state_q == ST_ACK) && rw_q;
        rdata    = rdata_oe ? rd_q : '0;
    end

    // R6: the request and its fields stay put until granted.
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_sel));
    // R6: a grant turns into an acknowledge on the next cycle.
    a_r6_ack_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |=> !ack_n && !mem_req);
    // R8: acknowledge held while the host keeps the strobe.
    a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n && !cs_n && ds |=> !ack_n);
    // R8: acknowledge released after the strobe goes away.
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n && (cs_n || !ds) |=> ack_n);
    // R3: an idle port without a qualified strobe stays silent.
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n && !mem_req && (cs_n || !ds) |=> ack_n && !mem_req);
    // R10: the data memory is never written.
    a_r10_no_dm_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !(mem_we && mem_sel == SEL_DM));
endmodule

// File: rtl/host_access_port.sv
// Top of the parallel host access port. It joins the control register, the
// address decoder and the handshake engine. The memories sit outside, behind
// a request/grant pair driven by the switching core's schedule.
module host_access_port
    import hp_port_pkg::*;
#(
    parameter int CH_W     = 5,
    parameter int STREAM_W = 2,
    localparam int HA_W    = CH_W + 1,
    localparam int MA_W    = STREAM_W + CH_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hp_cs_n,
    input  logic                 hp_ds,
    input  logic                 hp_rw,
    input  logic [HA_W-1:0]      hp_addr,
    input  logic [HP_DATA_W-1:0] hp_wdata,
    output logic [HP_DATA_W-1:0] hp_rdata,
    output logic                 hp_rdata_oe,
    output logic                 hp_ack_n,
    output logic                 proc_en,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [1:0]           mem_sel,
    output logic [MA_W-1:0]      mem_addr,
    output logic [HP_DATA_W-1:0] mem_wdata,
    input  logic                 mem_gnt,
    input  logic [HP_DATA_W-1:0] mem_rdata
);
    logic                 ctl_wr_en;
    logic [HP_DATA_W-1:0] ctl_rd;
    logic                 split;
    hp_sel_e              msel;
    logic [STREAM_W-1:0]  stream;
    logic                 hit_ctl;
    logic                 hit_mem;
    hp_sel_e              tgt;
    hp_sel_e              sel_int;

    hp_ctl_reg #(.STREAM_W(STREAM_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (hp_wdata),
        .rd_data (ctl_rd),
        .split   (split),
        .proc_en (proc_en),
        .msel    (msel),
        .stream  (stream)
    );

    hp_decode #(.CH_W(CH_W)) u_dec (
        .addr    (hp_addr),
        .rw      (hp_rw),
        .split   (split),
        .msel    (msel),
        .hit_ctl (hit_ctl),
        .hit_mem (hit_mem),
        .tgt     (tgt)
    );

    hp_access_fsm #(.CH_W(CH_W), .STREAM_W(STREAM_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (hp_cs_n),
        .ds        (hp_ds),
        .rw        (hp_rw),
        .chan      (hp_addr[CH_W-1:0]),
        .stream    (stream),
        .wdata     (hp_wdata),
        .hit_ctl   (hit_ctl),
        .hit_mem   (hit_mem),
        .tgt       (tgt),
        .ctl_rd    (ctl_rd),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .ctl_wr_en (ctl_wr_en),
        .ack_n     (hp_ack_n),
        .rdata     (hp_rdata),
        .rdata_oe  (hp_rdata_oe),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_sel   (sel_int),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Export the target code as a plain vector.
    assign mem_sel = sel_int;
endmodule

// File: tb/sim_host_access_port.sv
`timescale 1ns/1ps
module sim_host_access_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_cs_n = 1'b1, hp_ds = 1'b0, hp_rw = 1'b1;
    logic [5:0] hp_addr = '0;
    logic [7:0] hp_wdata = '0;
    logic [7:0] hp_rdata;
    logic       hp_rdata_oe, hp_ack_n, proc_en;
    logic       mem_req, mem_we;
    logic [1:0] mem_sel;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_gnt = 1'b0;
    logic [7:0] mem_rdata = '0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    host_access_port u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [1:0] s, input logic [6:0] a);
        return {s, a[5:0]} ^ 8'h3C;
    endfunction

    // One host access. Called just after a falling edge.
    task automatic access(input logic rw_i, input logic [5:0] a, input logic [7:0] wd,
                          input int gdly, input int hold,
                          output logic [7:0] rd, output int lat, output logic saw,
                          output logic [1:0] s, output logic [6:0] ad,
                          output logic we, output logic [7:0] w);
        int cnt;
        cnt = 0; saw = 0; s = 0; ad = 0; we = 0; w = 0; rd = 0; lat = -1;
        hp_rw = rw_i; hp_addr = a; hp_wdata = wd; hp_cs_n = 1'b0; hp_ds = 1'b1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            mem_gnt = 1'b0;
            if (!hp_ack_n) begin
                lat = i;
                rd = hp_rdata;
                break;
            end
            if (mem_req) begin
                if (!saw) begin
                    saw = 1; s = mem_sel; ad = mem_addr; we = mem_we; w = mem_wdata;
                end else begin
                    chk("R6 request fields held", {mem_sel, mem_addr}, {s, ad});
                end
                if (cnt == gdly) begin
                    mem_gnt = 1'b1;
                    mem_rdata = model(mem_sel, mem_addr);
                end
                cnt++;
            end
        end
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R8 ack held", hp_ack_n, 1'b0);
        end
        hp_ds = 1'b0; hp_cs_n = 1'b1;
        @(negedge clk);
        chk("R8 ack released", hp_ack_n, 1'b1);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        logic [7:0] rd; int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        access(1'b0, 6'b000000, v, 0, 0, rd, lat, saw, s, ad, we, w);
    endtask

    task automatic ctl_read(output logic [7:0] v);
        int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        access(1'b1, 6'b000000, 8'h00, 0, 0, v, lat, saw, s, ad, we, w);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 ack idle", hp_ack_n, 1'b1);
        chk("R1 no request", mem_req, 1'b0);
        chk("R1 proc_en clear", proc_en, 1'b0);
        ctl_read(v);
        chk("R1 control reads zero", v, 8'h00);
    endtask

    task automatic t_ctl_reg();
        logic [7:0] rd, v; int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        access(1'b0, 6'b011100, 8'hFF, 0, 0, rd, lat, saw, s, ad, we, w);
        chk("R2 ctl latency", lat, 1);
        chk("R2 ctl no request", saw, 1'b0);
        chk("R4 proc_en set", proc_en, 1'b1);
        access(1'b1, 6'b010000, 8'h00, 0, 0, v, lat, saw, s, ad, we, w);
        chk("R2 reserved bits read zero", v, 8'hDB);
        ctl_write(8'h00);
        chk("R4 proc_en cleared", proc_en, 1'b0);
    endtask

    task automatic t_gating();
        logic [7:0] v;
        ctl_write(8'h09);
        hp_rw = 1'b0; hp_addr = 6'b000000; hp_wdata = 8'hFF;
        hp_cs_n = 1'b1; hp_ds = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 no ack without cs", hp_ack_n, 1'b1);
            chk("R3 no req without cs", mem_req, 1'b0);
        end
        hp_cs_n = 1'b0; hp_ds = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 no ack without ds", hp_ack_n, 1'b1);
        end
        hp_cs_n = 1'b1;
        @(negedge clk);
        ctl_read(v);
        chk("R3 control unchanged", v, 8'h09);
    endtask

    task automatic t_mem_targets();
        logic [7:0] rd; int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        ctl_write(8'b0000_1010);  // select 01, stream 2
        access(1'b0, 6'b100101, 8'h5A, 3, 0, rd, lat, saw, s, ad, we, w);
        chk("R5 CML select", s, 2'b01);
        chk("R5 address", ad, 7'b10_00101);
        chk("R11 write flag", we, 1'b1);
        chk("R11 write data", w, 8'h5A);
        chk("R6 latency grant+2", lat, 5);
        ctl_write(8'b0001_0001);  // select 10, stream 1
        access(1'b1, 6'b111111, 8'h00, 0, 2, rd, lat, saw, s, ad, we, w);
        chk("R5 CMH select", s, 2'b10);
        chk("R5 address", ad, 7'b01_11111);
        chk("R11 read flag", we, 1'b0);
        chk("R6 latency immediate grant", lat, 2);
        chk("R7 read data", rd, model(2'b10, 7'b01_11111));
        ctl_write(8'b0001_1011);  // select 11, stream 3
        access(1'b1, 6'b100011, 8'h00, 7, 0, rd, lat, saw, s, ad, we, w);
        chk("R5 DM select", s, 2'b11);
        chk("R7 DM read data", rd, model(2'b11, 7'b11_00011));
        chk("R6 latency long wait", lat, 9);
    endtask

    task automatic t_ignored();
        logic [7:0] rd, v; int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        ctl_write(8'b0001_1000);  // select DM
        access(1'b0, 6'b100001, 8'hAA, 0, 0, rd, lat, saw, s, ad, we, w);
        chk("R10 DM write no request", saw, 1'b0);
        chk("R10 DM write latency", lat, 1);
        ctl_write(8'b0000_0000);  // select none
        access(1'b1, 6'b100001, 8'h00, 0, 0, rd, lat, saw, s, ad, we, w);
        chk("R10 select none no request", saw, 1'b0);
        chk("R10 select none reads zero", rd, 8'h00);
        access(1'b0, 6'b000001, 8'hFF, 0, 0, rd, lat, saw, s, ad, we, w);
        chk("R10 unused address latency", lat, 1);
        ctl_read(v);
        chk("R10 unused address leaves control", v, 8'h00);
    endtask

    task automatic t_split();
        logic [7:0] rd; int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        ctl_write(8'b1001_0000);  // split, select CMH
        access(1'b1, 6'b100100, 8'h00, 1, 0, rd, lat, saw, s, ad, we, w);
        chk("R9 split read to DM", s, 2'b11);
        chk("R9 split read data", rd, model(2'b11, 7'b00_00100));
        access(1'b0, 6'b100100, 8'h77, 1, 0, rd, lat, saw, s, ad, we, w);
        chk("R9 split write to CML", s, 2'b01);
        chk("R9 split write data", w, 8'h77);
    endtask

    task automatic t_ack_hold();
        logic [7:0] rd; int lat; logic saw, we; logic [1:0] s; logic [6:0] ad; logic [7:0] w;
        ctl_write(8'b0000_1000);
        access(1'b1, 6'b100010, 8'h00, 2, 5, rd, lat, saw, s, ad, we, w);
        chk("R8 request seen once", saw, 1'b1);
        chk("R7 oe low after release", hp_rdata_oe, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_reg();
        t_gating();
        t_mem_targets();
        t_ignored();
        t_split();
        t_ack_hold();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule